// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

One down-counting timer channel for a chip that needs interval interrupts, one-shots, periodic pulses, tone-style square waves and single strobes from one counter. The channel runs on the system clock. A one-cycle enable (`tick_i`) marks each counting edge. A gate input holds, triggers or retriggers counting, depending on the mode.

Software writes a control word and then a 16-bit start value. The control word carries a 3-bit mode number and a binary/BCD flag. The start value is held as the reload value. The waveform appears on `out_o`, and the live count is always visible on `count_o`. A start value of zero gives the longest interval. The counter steps in plain binary, or in BCD where each 4-bit digit runs 9 down to 0.

Top module: `timer_channel`

## Requirements
- R1: After reset, `out_o` is 0, `count_o` is 0, and ticks change nothing until a start value is written.
- R2: A control write stops the channel and sets `out_o` to 0 for mode 0 and to 1 for every other mode. Mode numbers 6 and 7 behave as modes 2 and 3.
- R3: A start value of 0 gives the maximum count. On the first decrement it becomes 16'hFFFF in binary or 16'h9999 in BCD.
- R4: In BCD (flag = 1) each nibble decrements with a borrow from the nibble above, so 16'h0100 steps to 16'h0099.
- R5: In mode 0, writing N drives `out_o` low. The output goes high on the Nth tick counted while the gate is high and stays high until the next write. Ticks with the gate low are not counted.
- R6: In mode 1, a gate rising edge seen at a tick loads N and drives `out_o` low. The output returns high N ticks later. A new rising edge during the low time reloads N.
- R7: In mode 2 with the gate high, `out_o` is high for N-1 ticks and low for 1 tick, and the count reloads on its own each period.
- R8: In mode 3, `out_o` is high for (N+1)/2 ticks and low for N/2 ticks (integer division), so an odd N gives the longer high phase. The count steps by two in each half.
- R9: In mode 4, counting starts when N is written. `out_o` stays high for N ticks, goes low for exactly 1 tick, then stays high with no reload.
- R10: Mode 5 matches mode 4, except that counting starts only on a gate rising edge seen at a tick. Writing N alone does not start it.
- R11: In modes 2 and 3, a tick with the gate low forces `out_o` high and holds the count. A gate rising edge reloads N.
- R12: The count and the output change only on a tick or a write. A control write takes priority over a count write, and a count write takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle counting-edge enable |
| gate_i | input | 1 | Gate level; sampled on ticks |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_mode_i | input | 3 | Mode number 0..7 |
| ctrl_bcd_i | input | 1 | 1 = BCD counting, 0 = binary |
| load_we_i | input | 1 | Start value write strobe |
| load_val_i | input | 16 | Start value N (0 = maximum) |
| out_o | output | 1 | Timer waveform |
| count_o | output | 16 | Live count |

## Verification
The hardest states to reach are the gate-edge cases. These are a mode 1 retrigger that arrives while the output is already low, and a gate drop in mode 2 that lands exactly in the single low tick.

A gate edge only counts when the gate level differs between two ticks. The stimulus therefore walks the gate through a low tick and then a high tick at a chosen point of a running count. It then counts ticks to the expected output change.

Mode 3 odd/even halves and the BCD wrap are driven from a vector table that measures the lengths of the first high and low phases in ticks.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    M_TC     = 3'd0,
    M_ONESHT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } tmode_e;

  // 6/7 alias onto 2/3
  function automatic tmode_e fold_mode(input logic [2:0] m);
    if (m[2:1] == 2'b11) return tmode_e'({1'b0, m[1:0]});
    return tmode_e'(m);
  endfunction
endpackage

// File: rtl/timer_dec.sv
module timer_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] dec_o
);
  localparam int ND = W / 4;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [3:0] d;
    logic       brw;
    assign d = val_i[4*i +: 4];
    if (i == 0) begin : g_lsd
      assign brw = 1'b1;
    end else begin : g_up
      // borrow reaches this digit only through all-zero lower digits
      assign brw = (val_i[4*i-1:0] == '0);
    end
    assign dec_o[4*i +: 4] = !brw      ? d :
                             (d == '0) ? (bcd_i ? 4'd9 : 4'hF) :
                                         d - 4'd1;
  end
endmodule

// File: rtl/timer_gate_edge.sv
module timer_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  // reset high: a gate tied high never looks like a trigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gate_q <= 1'b1;
    else if (tick_i) gate_q <= gate_i;
  end

  assign rise_o = tick_i & gate_i & ~gate_q;
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             ctrl_we_i,
  input  logic [2:0]       ctrl_mode_i,
  input  logic             ctrl_bcd_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  tmode_e           mode_q, mode_d;
  logic             bcd_q, bcd_d;
  logic [CNT_W-1:0] reload_q, reload_d, count_q, count_d;
  logic             out_q, out_d, armed_q, armed_d, run_q, run_d;
  logic             strobe_q, strobe_d, hi_q, hi_d;
  logic [CNT_W-1:0] dec1, dec2;
  logic             gate_rise;

  timer_dec #(.W(CNT_W)) u_dec1 (.val_i(count_q), .bcd_i(bcd_q), .dec_o(dec1));
  timer_dec #(.W(CNT_W)) u_dec2 (.val_i(dec1),    .bcd_i(bcd_q), .dec_o(dec2));

  timer_gate_edge u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .gate_i(gate_i),
    .rise_o(gate_rise)
  );

  always_comb begin
    mode_d   = mode_q;
    bcd_d    = bcd_q;
    reload_d = reload_q;
    count_d  = count_q;
    out_d    = out_q;
    armed_d  = armed_q;
    run_d    = run_q;
    strobe_d = strobe_q;
    hi_d     = hi_q;
    if (ctrl_we_i) begin
      mode_d   = fold_mode(ctrl_mode_i);
      bcd_d    = ctrl_bcd_i;
      out_d    = (fold_mode(ctrl_mode_i) != M_TC);
      run_d    = 1'b0;
      armed_d  = 1'b0;
      strobe_d = 1'b0;
      hi_d     = 1'b1;
    end else if (load_we_i) begin
      reload_d = load_val_i;
      armed_d  = 1'b1;
      strobe_d = 1'b0;
      hi_d     = 1'b1;
      unique case (mode_q)
        M_TC: begin
          count_d = load_val_i;
          out_d   = 1'b0;
          run_d   = 1'b1;
        end
        M_ONESHT, M_HWSTB: begin
          out_d = 1'b1;
          run_d = 1'b0;
        end
        default: begin
          count_d = load_val_i;
          out_d   = 1'b1;
          run_d   = 1'b1;
        end
      endcase
    end else if (tick_i) begin
      unique case (mode_q)
        M_TC: begin
          if (run_q && gate_i) begin
            if (count_q == ONE) begin
              count_d = '0;
              out_d   = 1'b1;
              run_d   = 1'b0;
            end else count_d = dec1;
          end
        end
        M_ONESHT: begin
          if (gate_rise && armed_q) begin
            count_d = reload_q;
            out_d   = 1'b0;
            run_d   = 1'b1;
          end else if (run_q) begin
            if (count_q == ONE) begin
              count_d = '0;
              out_d   = 1'b1;
              run_d   = 1'b0;
            end else count_d = dec1;
          end
        end
        M_RATE: begin
          if (armed_q) begin
            if (!gate_i) out_d = 1'b1;
            else if (gate_rise || count_q == ONE) begin
              count_d = reload_q;
              out_d   = 1'b1;
            end else begin
              count_d = dec1;
              out_d   = (dec1 != ONE);
            end
          end
        end
        M_SQUARE: begin
          if (armed_q) begin
            if (!gate_i) out_d = 1'b1;
            else if (gate_rise) begin
              count_d = reload_q;
              out_d   = 1'b1;
              hi_d    = 1'b1;
            end else if (count_q == ONE || count_q == TWO) begin
              hi_d    = !hi_q;
              out_d   = !hi_q;
              // low half starts from the even part of N
              count_d = hi_q ? {reload_q[CNT_W-1:1], 1'b0} : reload_q;
            end else count_d = dec2;
          end
        end
        default: begin // software and hardware strobe
          if (strobe_q) begin
            out_d    = 1'b1;
            strobe_d = 1'b0;
          end
          if (mode_q == M_HWSTB && gate_rise && armed_q) begin
            count_d = reload_q;
            out_d   = 1'b1;
            run_d   = 1'b1;
          end else if (run_q && (gate_i || mode_q == M_HWSTB)) begin
            if (count_q == ONE) begin
              count_d  = '0;
              out_d    = 1'b0;
              run_d    = 1'b0;
              strobe_d = 1'b1;
            end else count_d = dec1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_TC;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
      out_q    <= 1'b0;
      armed_q  <= 1'b0;
      run_q    <= 1'b0;
      strobe_q <= 1'b0;
      hi_q     <= 1'b1;
    end else begin
      mode_q   <= mode_d;
      bcd_q    <= bcd_d;
      reload_q <= reload_d;
      count_q  <= count_d;
      out_q    <= out_d;
      armed_q  <= armed_d;
      run_q    <= run_d;
      strobe_q <= strobe_d;
      hi_q     <= hi_d;
    end
  end

  assign out_o   = out_q;
  assign count_o = count_q;

  a_r12_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctrl_we_i && !load_we_i) |=> ($stable(count_q) && $stable(out_q)));

  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (out_q == (($past(ctrl_mode_i) != 3'd0))));

  a_r5_high_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_TC && out_q && !ctrl_we_i && !load_we_i) |=> out_q);

  a_r7_single_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_RATE && !out_q && tick_i && !ctrl_we_i && !load_we_i) |=> out_q);

  a_r9_strobe_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && tick_i && !ctrl_we_i && !load_we_i) |=> out_q);

  a_r11_gate_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == M_RATE || mode_q == M_SQUARE) && armed_q && tick_i && !gate_i
     && !ctrl_we_i && !load_we_i) |=> (out_q && $stable(count_q)));
endmodule

// File: tb/timer_channel_tb.sv
module timer_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 40;
  localparam int WD_CYCLES  = 100000;
  localparam int NV         = 11;

  // {mode, bcd, N, initial out, ticks to 1st change, ticks to 2nd change (0 = none)}
  localparam logic [43:0] VEC [NV] = '{
    {4'd0, 4'd0, 16'd7,    4'd0, 8'd7,  8'd0},  // R5
    {4'd2, 4'd0, 16'd5,    4'd1, 8'd4,  8'd1},  // R7
    {4'd2, 4'd0, 16'd18,   4'd1, 8'd17, 8'd1},  // R7
    {4'd2, 4'd1, 16'h0010, 4'd1, 8'd9,  8'd1},  // R7 R4
    {4'd3, 4'd0, 16'd6,    4'd1, 8'd3,  8'd3},  // R8
    {4'd3, 4'd0, 16'd5,    4'd1, 8'd3,  8'd2},  // R8
    {4'd3, 4'd0, 16'd3,    4'd1, 8'd2,  8'd1},  // R8
    {4'd3, 4'd1, 16'h0011, 4'd1, 8'd6,  8'd5},  // R8 R4
    {4'd4, 4'd0, 16'd4,    4'd1, 8'd4,  8'd1},  // R9
    {4'd6, 4'd0, 16'd4,    4'd1, 8'd3,  8'd1},  // R2 alias
    {4'd4, 4'd1, 16'h0012, 4'd1, 8'd12, 8'd1}   // R9 R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, gate = 1'b1, cwe = 1'b0, lwe = 1'b0, bcd = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] val = '0;
  logic        out;
  logic [15:0] cnt;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate_i(gate),
    .ctrl_we_i(cwe), .ctrl_mode_i(mode), .ctrl_bcd_i(bcd),
    .load_we_i(lwe), .load_val_i(val), .out_o(out), .count_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic ctrl(input logic [2:0] m, input logic b);
    @(negedge clk) begin cwe = 1'b1; mode = m; bcd = b; end
    @(negedge clk) cwe = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk) begin lwe = 1'b1; val = v; end
    @(negedge clk) lwe = 1'b0;
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    for (int i = 1; i <= LIM; i++) begin
      ticks(1);
      if (out != lvl) begin n = i; return; end
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset out", out, 0);
    chk("R1 reset count", cnt, 0);
    ticks(3);
    chk("R1 idle out", out, 0);
    chk("R1 idle count", cnt, 0);

    for (int k = 0; k < NV; k++) begin
      logic [43:0] v;
      v = VEC[k];
      gate = 1'b1;
      ctrl(v[42:40], v[36]);
      chk($sformatf("R2 row%0d idle level", k), out, v[16]);
      load(v[35:20]);
      measure(v[16], t1);
      chk($sformatf("row%0d first phase", k), t1, v[15:8]);
      t2 = 0;
      if (t1 != 0) measure(!v[16], t2);
      chk($sformatf("row%0d second phase", k), t2, v[7:0]);
    end

    // R9: after strobe, no reload
    ticks(10);
    chk("R9 stays high", out, 1);
    chk("R9 count stays 0", cnt, 0);

    // R3 maximum count
    ctrl(3'd2, 1'b0); load(16'd0); ticks(1);
    chk("R3 binary zero", cnt, 16'hFFFF);
    ctrl(3'd2, 1'b1); load(16'd0); ticks(1);
    chk("R3 bcd zero", cnt, 16'h9999);

    // R4 nibble borrow
    ctrl(3'd2, 1'b1); load(16'h0100); ticks(1);
    chk("R4 borrow", cnt, 16'h0099);
    ticks(1);
    chk("R4 next", cnt, 16'h0098);

    // R5 gate pause
    ctrl(3'd0, 1'b0); load(16'd3);
    gate = 1'b0; ticks(5);
    chk("R5 paused count", cnt, 3);
    chk("R5 paused out", out, 0);
    gate = 1'b1; ticks(2);
    chk("R5 still low", out, 0);
    chk("R5 count", cnt, 1);
    ticks(1);
    chk("R5 terminal", out, 1);
    ticks(3);
    chk("R5 latched", out, 1);
    load(16'd2);
    chk("R5 rewrite low", out, 0);

    // R6 one-shot
    ctrl(3'd1, 1'b0);
    chk("R2 mode1 idle", out, 1);
    load(16'd3); ticks(2);
    chk("R6 no trigger", out, 1);
    gate = 1'b0; ticks(1);
    gate = 1'b1; ticks(1);
    chk("R6 trigger out", out, 0);
    chk("R6 trigger count", cnt, 3);
    ticks(2);
    chk("R6 low", out, 0);
    ticks(1);
    chk("R6 end", out, 1);
    gate = 1'b0; ticks(1);
    gate = 1'b1; ticks(2);
    chk("R6 second run", cnt, 2);
    gate = 1'b0; ticks(1);
    gate = 1'b1; ticks(1);
    chk("R6 retrigger count", cnt, 3);
    chk("R6 retrigger out", out, 0);
    ticks(2);
    chk("R6 retrig low", out, 0);
    ticks(1);
    chk("R6 retrig end", out, 1);

    // R10 hardware strobe
    ctrl(3'd5, 1'b0); load(16'd2); ticks(3);
    chk("R10 waits", out, 1);
    chk("R10 no count", cnt, 0);
    gate = 1'b0; ticks(1);
    gate = 1'b1; ticks(1);
    chk("R10 started", cnt, 2);
    ticks(1);
    chk("R10 high", out, 1);
    ticks(1);
    chk("R10 strobe", out, 0);
    ticks(1);
    chk("R10 restored", out, 1);

    // R11 gate in rate mode
    ctrl(3'd2, 1'b0); load(16'd4); ticks(3);
    chk("R7 low tick", out, 0);
    gate = 1'b0; ticks(1);
    chk("R11 forced high", out, 1);
    chk("R11 held", cnt, 1);
    ticks(1);
    chk("R11 still held", cnt, 1);
    gate = 1'b1; ticks(1);
    chk("R11 reload", cnt, 4);
    ticks(3);
    chk("R11 period after reload", out, 0);

    // R11 square mode, then R2 stop
    ctrl(3'd3, 1'b0); load(16'd6); ticks(1);
    chk("R8 step two", cnt, 4);
    gate = 1'b0; ticks(1);
    chk("R11 sq hold", cnt, 4);
    gate = 1'b1; ticks(1);
    chk("R11 sq reload", cnt, 6);
    ctrl(3'd0, 1'b0);
    chk("R2 mode0 low", out, 0);
    ticks(3);
    chk("R2 stopped", cnt, 6);
    ctrl(3'd7, 1'b0);
    chk("R2 mode7 high", out, 1);

    // R12 no change without tick
    ctrl(3'd2, 1'b0); load(16'd9);
    repeat (5) @(negedge clk);
    chk("R12 no tick", cnt, 9);
    ticks(1);
    chk("R12 tick", cnt, 8);
    @(negedge clk) begin cwe = 1'b1; mode = 3'd4; lwe = 1'b1; val = 16'd5; tick = 1'b1; end
    @(negedge clk) begin cwe = 1'b0; lwe = 1'b0; tick = 1'b0; end
    chk("R12 ctrl wins", cnt, 8);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule